// File: doc/BRIEF.md
# Precise Exception Controller for a Five-Stage Pipeline

This block steers exceptions in an in-order integer pipeline with a single branch delay slot. Each stage reports a valid bit, an exception request, a small cause code and its program counter. When one or more valid stages request an exception, the controller takes the oldest one, which is the deepest stage. In the same cycle it disables architectural writes for that instruction and for every younger one, and it redirects fetch to a fixed handler vector. Older instructions still complete.

Because of the delay slot, the instructions in flight may not follow one another in address order. On the capture edge the controller therefore stores a chain of program counters: the faulting instruction's counter and the counter of the instruction that followed it in the pipeline. If the fault was raised in fetch, the next fetch address is stored instead. It also stores a cause record holding the code and the stage index. Further requests are ignored while the handler runs. A return strobe makes the controller replay the stored counters to fetch, one per cycle, and then accept exceptions again.

Top module: `exc_ctrl`

## Requirements
- R1: While rst_ni is low and right after reset, kill_o is all zero, redirect_valid_o is 0, and epc_o, cause_code_o and cause_stage_o are zero.
- R2: A stage counts as requesting only when valid_i[s] and exc_req_i[s] are both 1. Among the requesting stages, the one with the highest index (the oldest instruction) is taken. A request on a stage whose valid bit is 0 causes no kill and no redirect.
- R3: In the cycle an exception at stage f is taken, kill_o[s] is 1 for every s <= f and 0 for every s > f. Stage 0 is fetch and stage NSTG-1 is write-back.
- R4: In that same cycle, redirect_valid_o is 1 and redirect_pc_o equals the parameter VECTOR.
- R5: From the next clock edge on, epc_o[XLEN-1:0] holds the pc of stage f and epc_o[2*XLEN-1:XLEN] holds the pc of stage f-1. When f is 0, the upper entry holds nxt_pc_i.
- R6: On that same edge, cause_code_o captures exc_code_i of stage f (stage s uses bits [s*CODE_W +: CODE_W]) and cause_stage_o captures f.
- R7: From the capture edge until the replay finishes, requests are masked: kill_o stays 0, no redirect to VECTOR is produced, and epc_o and the cause outputs keep their values.
- R8: A one-cycle eret_i while the handler is active produces redirect_valid_o with redirect_pc_o equal to the lower epc_o entry in that cycle, and the upper entry in the following cycle. After that, redirect_valid_o returns to 0.
- R9: The cycle after the last replay redirect, a new exception request is taken again as in R3 to R6.
- R10: eret_i while no handler is active has no effect: no redirect is produced and epc_o is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | NSTG | Per-stage instruction valid |
| exc_req_i | input | NSTG | Per-stage exception request |
| exc_code_i | input | NSTG*CODE_W | Per-stage cause code, stage s at [s*CODE_W +: CODE_W] |
| pc_i | input | NSTG*XLEN | Per-stage program counter, stage s at [s*XLEN +: XLEN] |
| nxt_pc_i | input | XLEN | Address fetch would issue next |
| eret_i | input | 1 | Return-from-exception strobe |
| kill_o | output | NSTG | Per-stage write suppress and valid clear |
| redirect_valid_o | output | 1 | Fetch redirect request |
| redirect_pc_o | output | XLEN | Fetch redirect target |
| epc_o | output | (DELAY+1)*XLEN | Saved counter chain, entry k at [k*XLEN +: XLEN] |
| cause_code_o | output | CODE_W | Captured cause code |
| cause_stage_o | output | $clog2(NSTG) | Index of the stage that faulted |

## Verification
The bench builds the block with NSTG=5, XLEN=32, CODE_W=4 and DELAY=1, so the chain has two entries. This brings within reach every fault position from fetch to write-back, including the fetch case where the second entry comes from nxt_pc_i. It also covers simultaneous faults in non-adjacent stages, where the oldest must win. With a one-slot delay, the replay lasts exactly two cycles, so the bench can check each step of the handler entry, the masking and the return.

// File: rtl/exc_pkg.sv
package exc_pkg;
  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_HANDLER = 2'd1,
    ST_REPLAY  = 2'd2
  } exc_state_e;
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter #(
  parameter int NSTG   = 5,
  parameter int CODE_W = 4,
  localparam int STG_W = $clog2(NSTG)
) (
  input  logic [NSTG-1:0]        valid_i,
  input  logic [NSTG-1:0]        req_i,
  input  logic [NSTG*CODE_W-1:0] code_i,
  input  logic                   mask_i,
  output logic                   take_o,
  output logic [STG_W-1:0]       sel_o,
  output logic [CODE_W-1:0]      code_o
);
  logic [NSTG-1:0] hit;

  for (genvar s = 0; s < NSTG; s++) begin : g_hit
    assign hit[s] = valid_i[s] & req_i[s] & ~mask_i;
  end

  // ascending scan: the deepest (oldest) hit overwrites
  always_comb begin
    sel_o  = '0;
    code_o = '0;
    for (int s = 0; s < NSTG; s++) begin
      if (hit[s]) begin
        sel_o  = STG_W'(s);
        code_o = code_i[s*CODE_W +: CODE_W];
      end
    end
  end

  assign take_o = |hit;
endmodule

// File: rtl/exc_squash.sv
module exc_squash #(
  parameter int NSTG   = 5,
  localparam int STG_W = $clog2(NSTG)
) (
  input  logic             take_i,
  input  logic [STG_W-1:0] sel_i,
  output logic [NSTG-1:0]  kill_o
);
  for (genvar s = 0; s < NSTG; s++) begin : g_kill
    assign kill_o[s] = take_i && (STG_W'(s) <= sel_i);
  end
endmodule

// File: rtl/exc_epc_chain.sv
module exc_epc_chain #(
  parameter int NSTG   = 5,
  parameter int XLEN   = 32,
  parameter int DELAY  = 1,
  localparam int STG_W = $clog2(NSTG),
  localparam int NEPC  = DELAY + 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 take_i,
  input  logic [STG_W-1:0]     sel_i,
  input  logic [NSTG*XLEN-1:0] pc_i,
  input  logic [XLEN-1:0]      nxt_pc_i,
  output logic [NEPC*XLEN-1:0] epc_o
);
  // seq[0] is the next fetch address, seq[s+1] is the pc of stage s
  logic [XLEN-1:0] seq [NSTG+1];
  logic [NEPC*XLEN-1:0] cand;

  assign seq[0] = nxt_pc_i;
  for (genvar s = 0; s < NSTG; s++) begin : g_seq
    assign seq[s+1] = pc_i[s*XLEN +: XLEN];
  end

  for (genvar k = 0; k < NEPC; k++) begin : g_cand
    always_comb begin
      int src;
      src = int'(sel_i) + 1 - k;
      if (src < 0) src = 0;
      cand[k*XLEN +: XLEN] = seq[src];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     epc_o <= '0;
    else if (take_i) epc_o <= cand;
  end
endmodule

// File: rtl/exc_fsm.sv
module exc_fsm
  import exc_pkg::*;
#(
  parameter int DELAY  = 1,
  localparam int IDX_W = (DELAY > 0) ? $clog2(DELAY + 1) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  logic             eret_i,
  output logic             mask_o,
  output logic             rep_valid_o,
  output logic [IDX_W-1:0] rep_idx_o
);
  exc_state_e st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  always_comb begin
    st_d        = st_q;
    idx_d       = idx_q;
    rep_valid_o = 1'b0;
    rep_idx_o   = '0;
    unique case (st_q)
      ST_RUN: if (take_i) st_d = ST_HANDLER;
      ST_HANDLER: begin
        if (eret_i) begin
          rep_valid_o = 1'b1;
          idx_d       = IDX_W'(1);
          st_d        = (DELAY == 0) ? ST_RUN : ST_REPLAY;
        end
      end
      ST_REPLAY: begin
        rep_valid_o = 1'b1;
        rep_idx_o   = idx_q;
        if (idx_q == IDX_W'(DELAY)) st_d = ST_RUN;
        else                        idx_d = idx_q + 1'b1;
      end
      default: st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_RUN;
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
    end
  end

  assign mask_o = (st_q != ST_RUN);
endmodule

// File: rtl/exc_ctrl.sv
module exc_ctrl #(
  parameter int          NSTG   = 5,
  parameter int          XLEN   = 32,
  parameter int          CODE_W = 4,
  parameter int          DELAY  = 1,
  parameter logic [31:0] VECTOR = 32'h8000_0180,
  localparam int STG_W = $clog2(NSTG),
  localparam int NEPC  = DELAY + 1,
  localparam int IDX_W = (DELAY > 0) ? $clog2(DELAY + 1) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NSTG-1:0]        valid_i,
  input  logic [NSTG-1:0]        exc_req_i,
  input  logic [NSTG*CODE_W-1:0] exc_code_i,
  input  logic [NSTG*XLEN-1:0]   pc_i,
  input  logic [XLEN-1:0]        nxt_pc_i,
  input  logic                   eret_i,
  output logic [NSTG-1:0]        kill_o,
  output logic                   redirect_valid_o,
  output logic [XLEN-1:0]        redirect_pc_o,
  output logic [NEPC*XLEN-1:0]   epc_o,
  output logic [CODE_W-1:0]      cause_code_o,
  output logic [STG_W-1:0]       cause_stage_o
);
  logic              mask, take, rep_valid;
  logic [STG_W-1:0]  sel;
  logic [CODE_W-1:0] sel_code;
  logic [IDX_W-1:0]  rep_idx;

  exc_arbiter #(.NSTG(NSTG), .CODE_W(CODE_W)) u_arb (
    .valid_i (valid_i),
    .req_i   (exc_req_i),
    .code_i  (exc_code_i),
    .mask_i  (mask),
    .take_o  (take),
    .sel_o   (sel),
    .code_o  (sel_code)
  );

  exc_squash #(.NSTG(NSTG)) u_sq (
    .take_i (take),
    .sel_i  (sel),
    .kill_o (kill_o)
  );

  exc_epc_chain #(.NSTG(NSTG), .XLEN(XLEN), .DELAY(DELAY)) u_epc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .take_i   (take),
    .sel_i    (sel),
    .pc_i     (pc_i),
    .nxt_pc_i (nxt_pc_i),
    .epc_o    (epc_o)
  );

  exc_fsm #(.DELAY(DELAY)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .take_i      (take),
    .eret_i      (eret_i),
    .mask_o      (mask),
    .rep_valid_o (rep_valid),
    .rep_idx_o   (rep_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_code_o  <= '0;
      cause_stage_o <= '0;
    end else if (take) begin
      cause_code_o  <= sel_code;
      cause_stage_o <= sel;
    end
  end

  always_comb begin
    redirect_valid_o = take | rep_valid;
    redirect_pc_o    = XLEN'(VECTOR);
    if (!take && rep_valid) redirect_pc_o = epc_o[int'(rep_idx)*XLEN +: XLEN];
  end
endmodule

// File: rtl/exc_ctrl_chk.sv
module exc_ctrl_chk #(
  parameter int          NSTG   = 5,
  parameter int          XLEN   = 32,
  parameter int          CODE_W = 4,
  parameter int          DELAY  = 1,
  parameter logic [31:0] VECTOR = 32'h8000_0180,
  localparam int STG_W = $clog2(NSTG),
  localparam int NEPC  = DELAY + 1
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [NSTG-1:0]        valid_i,
  input logic [NSTG-1:0]        exc_req_i,
  input logic [NSTG*CODE_W-1:0] exc_code_i,
  input logic [NSTG*XLEN-1:0]   pc_i,
  input logic [NSTG-1:0]        kill_o,
  input logic                   redirect_valid_o,
  input logic [XLEN-1:0]        redirect_pc_o,
  input logic [NEPC*XLEN-1:0]   epc_o,
  input logic [CODE_W-1:0]      cause_code_o,
  input logic [STG_W-1:0]       cause_stage_o
);
  int              f_idx;
  logic [XLEN-1:0] pc_f;
  logic [CODE_W-1:0] code_f;
  logic [NSTG-1:0] req_above;

  always_comb begin
    f_idx  = $countones(kill_o) - 1;
    if (f_idx < 0) f_idx = 0;
    pc_f   = pc_i[f_idx*XLEN +: XLEN];
    code_f = exc_code_i[f_idx*CODE_W +: CODE_W];
    req_above = (valid_i & exc_req_i) >> (f_idx + 1);
  end

  assert_kill_prefix_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((kill_o & (kill_o + 1'b1)) == '0));

  assert_redirect_vec_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |kill_o |-> (redirect_valid_o && redirect_pc_o == XLEN'(VECTOR)));

  assert_oldest_wins_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |kill_o |-> (req_above == '0));

  assert_epc_capture_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |kill_o |=> (epc_o[XLEN-1:0] == $past(pc_f)));

  assert_cause_capture_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |kill_o |=> (cause_code_o == $past(code_f) &&
                 cause_stage_o == $past(STG_W'(f_idx))));

  assert_masked_after_take_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |kill_o |=> (kill_o == '0));

  assert_epc_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|kill_o) |=> $stable(epc_o));
endmodule

bind exc_ctrl exc_ctrl_chk #(
  .NSTG(NSTG), .XLEN(XLEN), .CODE_W(CODE_W), .DELAY(DELAY), .VECTOR(VECTOR)
) u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .valid_i          (valid_i),
  .exc_req_i        (exc_req_i),
  .exc_code_i       (exc_code_i),
  .pc_i             (pc_i),
  .kill_o           (kill_o),
  .redirect_valid_o (redirect_valid_o),
  .redirect_pc_o    (redirect_pc_o),
  .epc_o            (epc_o),
  .cause_code_o     (cause_code_o),
  .cause_stage_o    (cause_stage_o)
);

// File: tb/tb_exc_ctrl.sv
module tb_exc_ctrl;
  localparam int          NSTG   = 5;
  localparam int          XLEN   = 32;
  localparam int          CODE_W = 4;
  localparam int          DELAY  = 1;
  localparam logic [31:0] VEC    = 32'h8000_0180;
  localparam int          STG_W  = $clog2(NSTG);

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [NSTG-1:0]        valid_i = '0;
  logic [NSTG-1:0]        exc_req_i = '0;
  logic [NSTG*CODE_W-1:0] exc_code_i = '0;
  logic [NSTG*XLEN-1:0]   pc_i = '0;
  logic [XLEN-1:0]        nxt_pc_i = '0;
  logic                   eret_i = 1'b0;
  logic [NSTG-1:0]        kill_o;
  logic                   redirect_valid_o;
  logic [XLEN-1:0]        redirect_pc_o;
  logic [(DELAY+1)*XLEN-1:0] epc_o;
  logic [CODE_W-1:0]      cause_code_o;
  logic [STG_W-1:0]       cause_stage_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10 clk_i = ~clk_i;

  exc_ctrl #(.NSTG(NSTG), .XLEN(XLEN), .CODE_W(CODE_W), .DELAY(DELAY), .VECTOR(VEC)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .exc_req_i(exc_req_i),
    .exc_code_i(exc_code_i), .pc_i(pc_i), .nxt_pc_i(nxt_pc_i), .eret_i(eret_i),
    .kill_o(kill_o), .redirect_valid_o(redirect_valid_o), .redirect_pc_o(redirect_pc_o),
    .epc_o(epc_o), .cause_code_o(cause_code_o), .cause_stage_o(cause_stage_o)
  );

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [XLEN-1:0] pc_of(logic [XLEN-1:0] base, int s);
    return base - XLEN'(4 * s);
  endfunction

  task automatic set_pipe(logic [XLEN-1:0] base);
    for (int s = 0; s < NSTG; s++) begin
      pc_i[s*XLEN +: XLEN]         = pc_of(base, s);
      exc_code_i[s*CODE_W +: CODE_W] = CODE_W'(s + 3);
    end
    nxt_pc_i = base + 32'd4;
  endtask

  function automatic logic [NSTG-1:0] kmask(int f);
    return NSTG'((1 << (f + 1)) - 1);
  endfunction

  // drive a fault pattern, check the take cycle and the captured state
  task automatic take(string req, logic [XLEN-1:0] base, logic [NSTG-1:0] v,
                      logic [NSTG-1:0] r, int f);
    logic [XLEN-1:0] e1;
    @(negedge clk_i);
    set_pipe(base);
    valid_i = v;
    exc_req_i = r;
    #2;
    chk(req, "kill", 64'(kill_o), 64'(kmask(f)));
    chk("R4", "redir valid", 64'(redirect_valid_o), 64'd1);
    chk("R4", "redir pc", 64'(redirect_pc_o), 64'(VEC));
    @(negedge clk_i);
    valid_i = '0;
    exc_req_i = '0;
    e1 = (f == 0) ? base + 32'd4 : pc_of(base, f - 1);
    #2;
    chk("R5", "epc0", 64'(epc_o[XLEN-1:0]), 64'(pc_of(base, f)));
    chk("R5", "epc1", 64'(epc_o[2*XLEN-1:XLEN]), 64'(e1));
    chk("R6", "cause code", 64'(cause_code_o), 64'(f + 3));
    chk("R6", "cause stage", 64'(cause_stage_o), 64'(f));
  endtask

  task automatic do_eret(logic [XLEN-1:0] e0, logic [XLEN-1:0] e1);
    @(negedge clk_i);
    eret_i = 1'b1;
    #2;
    chk("R8", "replay0 valid", 64'(redirect_valid_o), 64'd1);
    chk("R8", "replay0 pc", 64'(redirect_pc_o), 64'(e0));
    @(negedge clk_i);
    eret_i = 1'b0;
    #2;
    chk("R8", "replay1 valid", 64'(redirect_valid_o), 64'd1);
    chk("R8", "replay1 pc", 64'(redirect_pc_o), 64'(e1));
    @(negedge clk_i);
    #2;
    chk("R8", "replay done", 64'(redirect_valid_o), 64'd0);
  endtask

  task automatic t_reset();
    #5;
    chk("R1", "kill in reset", 64'(kill_o), 64'd0);
    chk("R1", "redir in reset", 64'(redirect_valid_o), 64'd0);
    chk("R1", "epc in reset", 64'(epc_o), 64'd0);
    chk("R1", "cause in reset", 64'({cause_code_o, cause_stage_o}), 64'd0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    #2;
    chk("R1", "redir after reset", 64'(redirect_valid_o), 64'd0);
  endtask

  task automatic t_single_mem();
    take("R3", 32'h0000_1100, 5'b11111, 5'b01000, 3);
    do_eret(32'h0000_1100 - 12, 32'h0000_1100 - 8);
  endtask

  task automatic t_multi_oldest();
    take("R2", 32'h0000_2200, 5'b11111, 5'b10110, 4);
    do_eret(32'h0000_2200 - 16, 32'h0000_2200 - 12);
  endtask

  task automatic t_invalid_ignored();
    @(negedge clk_i);
    set_pipe(32'h0000_3300);
    valid_i = 5'b01111;
    exc_req_i = 5'b10000;
    #2;
    chk("R2", "invalid req kill", 64'(kill_o), 64'd0);
    chk("R2", "invalid req redir", 64'(redirect_valid_o), 64'd0);
    take("R2", 32'h0000_3300, 5'b00111, 5'b10100, 2);
    do_eret(32'h0000_3300 - 8, 32'h0000_3300 - 4);
  endtask

  task automatic t_masked();
    logic [63:0] ep;
    take("R3", 32'h0000_4400, 5'b11111, 5'b00100, 2);
    ep = 64'(epc_o);
    @(negedge clk_i);
    set_pipe(32'h0000_9900);
    valid_i = 5'b11111;
    exc_req_i = 5'b10001;
    #2;
    chk("R7", "masked kill", 64'(kill_o), 64'd0);
    chk("R7", "masked redir", 64'(redirect_valid_o), 64'd0);
    @(negedge clk_i);
    #2;
    chk("R7", "masked epc", 64'(epc_o), ep);
    chk("R7", "masked cause", 64'(cause_stage_o), 64'd2);
    valid_i = '0;
    exc_req_i = '0;
    // first replay cycle with a live request: must still be masked
    @(negedge clk_i);
    eret_i = 1'b1;
    valid_i = 5'b11111;
    exc_req_i = 5'b01000;
    #2;
    chk("R7", "kill during eret", 64'(kill_o), 64'd0);
    chk("R8", "replay0 pc", 64'(redirect_pc_o), 64'(32'h0000_4400 - 8));
    @(negedge clk_i);
    eret_i = 1'b0;
    #2;
    chk("R7", "kill during replay", 64'(kill_o), 64'd0);
    chk("R8", "replay1 pc", 64'(redirect_pc_o), 64'(32'h0000_4400 - 4));
    valid_i = '0;
    exc_req_i = '0;
    // R9: accepted again right after replay
    take("R9", 32'h0000_5500, 5'b11111, 5'b00010, 1);
    do_eret(32'h0000_5500 - 4, 32'h0000_5500);
  endtask

  task automatic t_fetch_fault();
    take("R3", 32'h0000_6600, 5'b11111, 5'b00001, 0);
    do_eret(32'h0000_6600, 32'h0000_6604);
  endtask

  task automatic t_eret_idle();
    logic [63:0] ep;
    ep = 64'(epc_o);
    @(negedge clk_i);
    eret_i = 1'b1;
    #2;
    chk("R10", "idle eret redir", 64'(redirect_valid_o), 64'd0);
    @(negedge clk_i);
    eret_i = 1'b0;
    #2;
    chk("R10", "idle eret next redir", 64'(redirect_valid_o), 64'd0);
    chk("R10", "idle eret epc", 64'(epc_o), ep);
    take("R10", 32'h0000_7700, 5'b11111, 5'b10000, 4);
    do_eret(32'h0000_7700 - 16, 32'h0000_7700 - 12);
  endtask

  initial begin
    t_reset();
    t_single_mem();
    t_multi_oldest();
    t_invalid_ignored();
    t_masked();
    t_fetch_fault();
    t_eret_idle();
    repeat (2) @(negedge clk_i);
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule